// File: doc/BRIEF.md
# Byte/Word Selectable Memory Bus Front End

This block sits between the external pins of a 16-bit memory and its storage. It turns the active-low chip-enable, output-enable, write-enable and reset pins into internal read and write strobes. It drives one output enable for each data pin, so a pad ring can build true tri-state pins from it. The storage behind it is a small word-wide array that stands in for the real memory.

A mode pin selects the bus width. When the pin is high the part works as a 16-bit memory. When the pin is low only the lower eight data pins carry data, and the upper seven stay undriven. The topmost data pin then becomes an extra address input that sits below the word address and picks one byte of the addressed word. The block also forms the internal byte address from the word address and that extra bit.

A parameter can build the block as word-only. In that build the mode pin has no effect.

Top module: `dual_width_bus_if`

## Requirements
- R1: A read is enabled only while reset is high, chip-enable is low, output-enable is low and write-enable is high. With chip-enable and output-enable low but write-enable also low, no data pin is enabled and `dqOut` is zero.
- R2: While chip-enable or output-enable is high, every bit of `dqOe` is 0 and `dqOut` is zero.
- R3: While `resetN` is low, every bit of `dqOe` is 0. A write strobe given during reset leaves the storage unchanged.
- R4: In word mode (`byteN` = 1), an enabled read sets `dqOe` to 16'hFFFF and presents the whole stored word at `addr` on `dqOut`.
- R5: In byte mode (`byteN` = 0), an enabled read sets `dqOe` to 16'h00FF. In that mode pins 15..8 are never enabled, and `dqOut[15:8]` is 0.
- R6: In byte mode, `dqIn[15]` is the lowest address bit. A value of 0 selects bits 7..0 of the word and 1 selects bits 15..8, and the selected byte appears on `dqOut[7:0]`. `byteAddr` is {`addr`, `dqIn[15]`} in byte mode and {`addr`, 0} in word mode.
- R7: In word mode, a rising clock edge with reset high, chip-enable low, write-enable low and output-enable high stores `dqIn` at `addr`.
- R8: A byte-mode write stores `dqIn[7:0]` into only the byte chosen by `dqIn[15]`. The other byte of the word keeps its value, and `dqIn[14:8]` is ignored.
- R9: With parameter `BYTE_CAPABLE` = 0, the `byteN` pin is ignored and the block always behaves as in word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| resetN | input | 1 | Active-low reset pin |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| byteN | input | 1 | Width select: 1 = word, 0 = byte |
| addr | input | ADDR_W | Word address |
| dqIn | input | WORD_W | Values seen on the data pins (bit 15 is the byte select in byte mode) |
| dqOut | output | WORD_W | Data to drive onto the pins |
| dqOe | output | WORD_W | Output enable for each data pin |
| byteAddr | output | ADDR_W+1 | Internal byte address |

## Verification
The bench aims at the pin enables in every mix of control pins that is almost a read:
- write-enable low during a read;
- only one of the two enables low;
- reset low while the other pins ask for a read.

A design that decoded any of these wrongly would drive the bus while the host also drives it.

In byte mode the bench flips the byte-select pin while putting junk on pins 14..8. A design that enabled the top pin, picked the wrong byte, or took junk into a byte write would show it on `dqOe`, `dqOut` or a later read-back.

A word-only build is given the same stimulus. This catches a mode pin that still leaks into that build.

// File: rtl/dwbus_pkg.sv
package dwbus_pkg;
  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic readEn;   // drive read data onto the active pins
    logic writeEn;  // commit the bus value this clock edge
    logic byteMode; // 8-bit bus; top pin is the byte select
  } bus_strobe_t;
endpackage

// File: rtl/dwbus_ctrl.sv
module dwbus_ctrl
  import dwbus_pkg::*;
#(
  parameter bit BYTE_CAPABLE = 1'b1
) (
  input  logic        resetN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        byteN,
  output bus_strobe_t strobe
);
  logic modeByte;

  generate
    if (BYTE_CAPABLE) begin : g_mode_pin
      assign modeByte = ~byteN;
    end else begin : g_word_only
      assign modeByte = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe.readEn   = resetN & ~ceN & ~oeN & weN;
    strobe.writeEn  = resetN & ~ceN & ~weN & oeN;
    strobe.byteMode = modeByte;
  end
endmodule

// File: rtl/dwbus_datapath.sv
module dwbus_datapath
  import dwbus_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              resetN,
  input  bus_strobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dqIn,
  output logic [WORD_W-1:0] dqOut,
  output logic [WORD_W-1:0] dqOe,
  output logic [ADDR_W:0]   byteAddr
);
  localparam int HALF  = WORD_W / 2;
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              hiSel;
  logic [WORD_W-1:0] wordRd;
  logic [HALF-1:0]   byteRd;

  // Top pin acts as the sub-word address bit in byte mode.
  assign hiSel    = strobe.byteMode & dqIn[WORD_W-1];
  assign byteAddr = {addr, hiSel};

  always_ff @(posedge clk) begin
    if (strobe.writeEn) begin
      if (!strobe.byteMode)
        mem[addr] <= dqIn;
      else if (hiSel)
        mem[addr][WORD_W-1:HALF] <= dqIn[HALF-1:0];
      else
        mem[addr][HALF-1:0] <= dqIn[HALF-1:0];
    end
  end

  assign wordRd = mem[addr];
  assign byteRd = hiSel ? wordRd[WORD_W-1:HALF] : wordRd[HALF-1:0];

  always_comb begin
    if (!strobe.readEn)
      dqOut = '0;
    else if (strobe.byteMode)
      dqOut = {{HALF{1'b0}}, byteRd};
    else
      dqOut = wordRd;
  end

  // Per-pin enables: lower half follows the read strobe, upper half is
  // additionally gated off in byte mode.
  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_pin
      if (i < HALF) begin : g_low
        assign dqOe[i] = strobe.readEn;
      end else begin : g_high
        assign dqOe[i] = strobe.readEn & ~strobe.byteMode;
      end
    end
  endgenerate

  // R7: a word write lands in full at the latched address
  assert_word_write_R7: assert property (@(posedge clk) disable iff (!resetN)
    (strobe.writeEn && !strobe.byteMode) |=> mem[$past(addr)] == $past(dqIn));

  // R8: a low-byte write leaves the high byte untouched
  assert_byte_keep_R8: assert property (@(posedge clk) disable iff (!resetN)
    (strobe.writeEn && strobe.byteMode && !dqIn[WORD_W-1])
      |=> mem[$past(addr)][WORD_W-1:HALF] == $past(mem[addr][WORD_W-1:HALF]));
endmodule

// File: rtl/dual_width_bus_if.sv
module dual_width_bus_if
  import dwbus_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int ADDR_W       = 4,
  parameter bit BYTE_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              resetN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              byteN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dqIn,
  output logic [WORD_W-1:0] dqOut,
  output logic [WORD_W-1:0] dqOe,
  output logic [ADDR_W:0]   byteAddr
);
  localparam int HALF = WORD_W / 2;

  bus_strobe_t strobe;

  dwbus_ctrl #(.BYTE_CAPABLE(BYTE_CAPABLE)) u_ctrl (
    .resetN(resetN), .ceN(ceN), .oeN(oeN), .weN(weN), .byteN(byteN),
    .strobe(strobe)
  );

  dwbus_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .resetN(resetN), .strobe(strobe), .addr(addr), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .byteAddr(byteAddr)
  );

  // R1: all read conditions met -> at least the low pins are driven
  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!resetN)
    (!ceN && !oeN && weN) |-> dqOe[0]);

  // R2: a deselected bus is never driven
  assert_hiz_deselect_R2: assert property (@(posedge clk) disable iff (!resetN)
    (ceN || oeN) |-> dqOe == '0);

  // R5: upper pins stay undriven in byte mode
  assert_byte_upper_off_R5: assert property (@(posedge clk) disable iff (!resetN)
    (BYTE_CAPABLE && !byteN) |-> dqOe[WORD_W-1:HALF] == '0);

  // R3: nothing driven while reset is low
  always @(posedge clk) begin
    if (resetN === 1'b0) begin
      assert_reset_hiz_R3: assert (dqOe == '0);
    end
  end
endmodule

// File: tb/dual_width_bus_if_bench.sv
module dual_width_bus_if_bench;
  logic        clk = 1'b0;
  logic        resetN = 1'b0, ceN = 1'b1, oeN = 1'b1, weN = 1'b1, byteN = 1'b1;
  logic [3:0]  addr = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] outA, oeA, outB, oeB;
  logic [4:0]  baA, baB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] memA [16];
  logic [15:0] memB [16];

  always #2 clk = ~clk;

  dual_width_bus_if u_dual_width_bus_if (
    .clk(clk), .resetN(resetN), .ceN(ceN), .oeN(oeN), .weN(weN), .byteN(byteN),
    .addr(addr), .dqIn(dqIn), .dqOut(outA), .dqOe(oeA), .byteAddr(baA)
  );

  dual_width_bus_if #(.BYTE_CAPABLE(1'b0)) u_word_only (
    .clk(clk), .resetN(resetN), .ceN(ceN), .oeN(oeN), .weN(weN), .byteN(byteN),
    .addr(addr), .dqIn(dqIn), .dqOut(outB), .dqOe(oeB), .byteAddr(baB)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, compare against the model, update model at posedge.
  task automatic cyc(string tag, logic r, logic c, logic o, logic w, logic b,
                     logic [3:0] a, logic [15:0] d);
    logic rd, wr, bm;
    logic [15:0] eOe, eOut, eOeB, eOutB;
    logic [7:0]  sel;
    @(negedge clk);
    resetN = r; ceN = c; oeN = o; weN = w; byteN = b; addr = a; dqIn = d;
    #1;
    rd = r & ~c & ~o & w;
    wr = r & ~c & ~w & o;
    bm = ~b;
    sel  = d[15] ? memA[a][15:8] : memA[a][7:0];
    eOe  = rd ? (bm ? 16'h00FF : 16'hFFFF) : 16'h0000;
    eOut = rd ? (bm ? {8'h00, sel} : memA[a]) : 16'h0000;
    eOeB  = rd ? 16'hFFFF : 16'h0000;
    eOutB = rd ? memB[a] : 16'h0000;
    chk(tag, "dqOe", {16'h0, oeA}, {16'h0, eOe});
    chk(tag, "dqOut", {16'h0, outA}, {16'h0, eOut});
    chk("R6", "byteAddr", {27'h0, baA}, {27'h0, (bm ? {a, d[15]} : {a, 1'b0})});
    chk(tag, "word-only dqOe (R9)", {16'h0, oeB}, {16'h0, eOeB});
    chk(tag, "word-only dqOut (R9)", {16'h0, outB}, {16'h0, eOutB});
    chk("R9", "word-only byteAddr", {27'h0, baB}, {27'h0, a, 1'b0});
    @(posedge clk);
    if (wr) begin
      memB[a] = d;
      if (!bm) memA[a] = d;
      else if (d[15]) memA[a][15:8] = d[7:0];
      else memA[a][7:0] = d[7:0];
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R3: reset held, read requested
    cyc("R3", 0, 0, 0, 1, 1, 4'd0, 16'h0000);
    cyc("R3", 0, 0, 0, 1, 0, 4'd1, 16'h8000);
    // R7: fill every word
    for (int i = 0; i < 16; i++)
      cyc("R7", 1, 0, 1, 0, 1, 4'(i), 16'(i * 16'h1357 + 16'h0A0B));
    // R4: read them back in word mode
    for (int i = 0; i < 16; i++)
      cyc("R4", 1, 0, 0, 1, 1, 4'(i), 16'h0000);
    // R3: write strobe during reset is dropped
    cyc("R3", 0, 0, 1, 0, 1, 4'd3, 16'hDEAD);
    cyc("R3", 1, 0, 0, 1, 1, 4'd3, 16'h0000);
    // R2: one of the enables high
    cyc("R2", 1, 1, 0, 1, 1, 4'd2, 16'h0000);
    cyc("R2", 1, 0, 1, 1, 1, 4'd2, 16'h0000);
    cyc("R2", 1, 1, 1, 1, 0, 4'd2, 16'h8000);
    // R1: write-enable low together with output-enable low -> no read, no write
    cyc("R1", 1, 0, 0, 0, 1, 4'd4, 16'hBEEF);
    cyc("R1", 1, 0, 0, 1, 1, 4'd4, 16'h0000);
    // R5 / R6: byte reads, junk on pins 14..0
    cyc("R5", 1, 0, 0, 1, 0, 4'd7, 16'h7F3C);
    cyc("R6", 1, 0, 0, 1, 0, 4'd7, 16'hFFFF);
    cyc("R6", 1, 0, 0, 1, 0, 4'd9, 16'h0000);
    cyc("R6", 1, 0, 0, 1, 0, 4'd9, 16'h8000);
    // R8: byte writes with junk on pins 14..8
    cyc("R8", 1, 0, 1, 0, 0, 4'd5, 16'h7FA5);
    cyc("R8", 1, 0, 1, 0, 0, 4'd6, 16'hFF5A);
    cyc("R8", 1, 0, 0, 1, 1, 4'd5, 16'h0000);
    cyc("R8", 1, 0, 0, 1, 1, 4'd6, 16'h0000);
    cyc("R8", 1, 0, 0, 1, 0, 4'd5, 16'h0000);
    cyc("R8", 1, 0, 0, 1, 0, 4'd6, 16'h8000);
    // R9: word-only build under byte mode pin (checked on the second instance)
    cyc("R9", 1, 0, 1, 0, 0, 4'd8, 16'h8123);
    cyc("R9", 1, 0, 0, 1, 0, 4'd8, 16'h8000);
    // Mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R4", lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[4], lfsr[5] | lfsr[9],
          lfsr[6], lfsr[11:8], {lfsr[7], lfsr[14:0]});
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule